// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

This block is a one-bit-wide serial delay line whose active depth can be set to any value from 1 to 64 stages. A six-bit length word picks the depth. A source-select input chooses which of two serial data inputs feeds the head stage. Tying one of those inputs to the block's own output turns the line into a recirculating loop. The last active stage drives a true output and its complement.

The block is fully synchronous to a free-running system clock. Two shift-clock inputs are brought into that clock domain through synchronisers, and their edges are detected there. A shift happens in either of two cases:
- the first shift clock rises while the second is low, or
- the second shift clock falls while the first is high.

An active-high clear input empties every stage at once, without waiting for a clock edge.

Top module: `varlen_shift_reg`

## Requirements
- R1: The active length is `lenSel + 1`, where bit k of `lenSel` has weight 2^k. `qOut` shows the stage at index `lenSel` (stage 0 is the head). A bit loaded into the head therefore reaches `qOut` after exactly `lenSel + 1` shift events.
- R2: `lenSel` = 0 gives a 1-stage line, and `lenSel` = 63 gives a 64-stage line.
- R3: When `srcSelA` is 1 the head loads `dinA`; when it is 0 the head loads `dinB`. Both are sampled in the system-clock cycle in which the shift is performed.
- R4: On a shift, the head takes the selected data bit and every other stage takes the value of the stage before it. Without a shift, no stage changes.
- R5: A rising edge on `shClkA` while `shClkB` is low causes one shift. A rising edge on `shClkA` while `shClkB` is high causes none.
- R6: A falling edge on `shClkB` while `shClkA` is high causes one shift. A falling edge on `shClkB` while `shClkA` is low causes none.
- R7: While `clear` is high, all stages are zero, `qOut` is 0 and `qOutN` is 1. This takes effect at once, without a clock edge, and overrides shifting.
- R8: `qOutN` is always the inverse of `qOut`.
- R9: Changing `lenSel` never alters stored bits. It only selects, combinationally, which stage drives `qOut`.
- R10: Each shift-clock input passes two synchronising flops. A change applied just after a system-clock edge causes a shift at the third following rising edge. At most one shift is done per system-clock cycle, even when both trigger conditions are met together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| clear | input | 1 | Asynchronous active-high clear of all stages |
| lenSel | input | 6 | Length word; active length is value + 1 |
| srcSelA | input | 1 | 1 selects dinA, 0 selects dinB |
| dinA | input | 1 | Serial data input A |
| dinB | input | 1 | Serial data input B |
| shClkA | input | 1 | Shift clock, rising-edge trigger gated by shClkB low |
| shClkB | input | 1 | Shift clock, falling-edge trigger gated by shClkA high |
| qOut | output | 1 | Value of the last active stage |
| qOutN | output | 1 | Complement of qOut |

## Verification
The following are checked on every system-clock cycle:
- No shift occurs when both synchronised shift clocks are at the same level.
- Every shift coincides with a synchronised clock change.
- The stages hold still without a shift, and on a shift they move by exactly one place with the head taking the selected bit.
- Clear forces the outputs to their cleared levels.

The bench scenarios cover what spans many cycles or needs a reference:
- arrival of a bit at `qOut` after exactly the programmed number of shifts, at several lengths including both extremes;
- the choice of data source;
- the three-edge latency;
- a single shift when both trigger conditions coincide;
- re-tapping stored data by changing the length word.

// File: rtl/shreg_pkg.sv
`timescale 1ns/1ps
package shreg_pkg;

  // Strobe bundle from control to datapath: one step request plus the bit to load.
  typedef struct packed {
    logic shiftEn;
    logic dataBit;
  } shiftStrobe_t;

endpackage

// File: rtl/shreg_ctrl.sv
`timescale 1ns/1ps
module shreg_ctrl
  import shreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         shClkA,
  input  logic         shClkB,
  input  logic         srcSelA,
  input  logic         dinA,
  input  logic         dinB,
  output shiftStrobe_t strobe
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] chainA;
  logic [TOP:0] chainB;
  logic         syncA;
  logic         syncB;
  logic         prevA;
  logic         prevB;
  logic         riseEvt;
  logic         fallEvt;

  // Synchroniser chains, one per shift-clock input.
  generate
    if (SYNC_STAGES > 1) begin : gMulti
      always_ff @(posedge clk or posedge clear) begin
        if (clear) begin
          chainA <= '0;
          chainB <= '0;
        end else begin
          chainA <= {chainA[TOP-1:0], shClkA};
          chainB <= {chainB[TOP-1:0], shClkB};
        end
      end
    end else begin : gSingle
      always_ff @(posedge clk or posedge clear) begin
        if (clear) begin
          chainA <= '0;
          chainB <= '0;
        end else begin
          chainA <= shClkA;
          chainB <= shClkB;
        end
      end
    end
  endgenerate

  assign syncA = chainA[TOP];
  assign syncB = chainB[TOP];

  // Previous synchronised levels, used for edge detection.
  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= syncA;
      prevB <= syncB;
    end
  end

  assign riseEvt = syncA & ~prevA & ~syncB;
  assign fallEvt = ~syncB & prevB & syncA;

  always_comb begin
    strobe.shiftEn = riseEvt | fallEvt;
    strobe.dataBit = srcSelA ? dinA : dinB;
  end

  AST_NO_STEP_BOTH_HIGH: assert property (@(posedge clk) disable iff (clear)
    (syncA && syncB) |-> !strobe.shiftEn); // R5

  AST_NO_STEP_BOTH_LOW: assert property (@(posedge clk) disable iff (clear)
    (!syncA && !syncB) |-> !strobe.shiftEn); // R6

  AST_STEP_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (clear)
    strobe.shiftEn |-> !$stable({syncA, syncB})); // R10

endmodule

// File: rtl/shreg_path.sv
`timescale 1ns/1ps
module shreg_path
  import shreg_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             clear,
  input  shiftStrobe_t     strobe,
  input  logic [LEN_W-1:0] lenSel,
  output logic             qOut,
  output logic             qOutN
);

  localparam int DEPTH = 1 << LEN_W;

  logic [DEPTH-1:0] stageReg;

  // Head stage loads the selected serial bit.
  always_ff @(posedge clk or posedge clear) begin
    if (clear)               stageReg[0] <= 1'b0;
    else if (strobe.shiftEn) stageReg[0] <= strobe.dataBit;
  end

  // Remaining stages each take their predecessor.
  generate
    for (genvar i = 1; i < DEPTH; i++) begin : gStage
      always_ff @(posedge clk or posedge clear) begin
        if (clear)               stageReg[i] <= 1'b0;
        else if (strobe.shiftEn) stageReg[i] <= stageReg[i-1];
      end
    end
  endgenerate

  // Output tap follows the length word combinationally.
  assign qOut  = stageReg[lenSel];
  assign qOutN = ~qOut;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clear)
    !strobe.shiftEn |=> $stable(stageReg)); // R4

  AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (clear)
    strobe.shiftEn |=> stageReg[0] == $past(strobe.dataBit)); // R4

  AST_MOVE_ONE: assert property (@(posedge clk) disable iff (clear)
    strobe.shiftEn |=> stageReg[DEPTH-1:1] == $past(stageReg[DEPTH-2:0])); // R4

  AST_CLEAR_OUT: assert property (@(posedge clk)
    clear |-> (!qOut && qOutN)); // R7

endmodule

// File: rtl/varlen_shift_reg.sv
`timescale 1ns/1ps
module varlen_shift_reg
  import shreg_pkg::*;
#(
  parameter int LEN_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [LEN_W-1:0] lenSel,
  input  logic             srcSelA,
  input  logic             dinA,
  input  logic             dinB,
  input  logic             shClkA,
  input  logic             shClkB,
  output logic             qOut,
  output logic             qOutN
);

  shiftStrobe_t strobe;

  shreg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .clear   (clear),
    .shClkA  (shClkA),
    .shClkB  (shClkB),
    .srcSelA (srcSelA),
    .dinA    (dinA),
    .dinB    (dinB),
    .strobe  (strobe)
  );

  shreg_path #(.LEN_W(LEN_W)) uPath (
    .clk    (clk),
    .clear  (clear),
    .strobe (strobe),
    .lenSel (lenSel),
    .qOut   (qOut),
    .qOutN  (qOutN)
  );

endmodule

// File: tb/tb_varlen_shift_reg.sv
`timescale 1ns/1ps
module tb_varlen_shift_reg;

  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic [5:0] lenSel = '0;
  logic       srcSelA = 1'b1;
  logic       dinA = 1'b0;
  logic       dinB = 1'b0;
  logic       shClkA = 1'b0;
  logic       shClkB = 1'b0;
  logic       qOut;
  logic       qOutN;

  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;
  logic [63:0] mdl = '0;

  always #2 clk = ~clk;

  varlen_shift_reg dut (
    .clk(clk), .clear(clear), .lenSel(lenSel), .srcSelA(srcSelA),
    .dinA(dinA), .dinB(dinB), .shClkA(shClkA), .shClkB(shClkB),
    .qOut(qOut), .qOutN(qOutN)
  );

  // Each entry: [7:2] length code, [1] use falling-edge trigger, [0] srcSelA.
  localparam logic [7:0] VEC [6] = '{
    {6'd0,  1'b0, 1'b1},
    {6'd1,  1'b1, 1'b1},
    {6'd5,  1'b0, 1'b0},
    {6'd17, 1'b1, 1'b0},
    {6'd32, 1'b0, 1'b1},
    {6'd63, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    shClkA = 1'b0;
    shClkB = 1'b0;
    clear  = 1'b1;
    settle();
    clear  = 1'b0;
    mdl    = '0;
    settle();
  endtask

  task automatic putData(input logic b);
    if (srcSelA) begin dinA = b; dinB = ~b; end
    else         begin dinB = b; dinA = ~b; end
  endtask

  task automatic shiftRise(input logic b);
    putData(b);
    shClkB = 1'b0;
    shClkA = 1'b1;
    settle();
    shClkA = 1'b0;
    settle();
    mdl = {mdl[62:0], b};
  endtask

  task automatic shiftFall(input logic b);
    putData(b);
    shClkB = 1'b1;
    settle();
    shClkA = 1'b1;
    settle();
    shClkB = 1'b0;
    settle();
    shClkA = 1'b0;
    settle();
    mdl = {mdl[62:0], b};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Reset state
    @(negedge clk);
    chk("R7 reset qOut", qOut, 1'b0);
    chk("R8 reset qOutN", qOutN, 1'b1);
    clear = 1'b0;
    settle();

    // Vector table walk
    for (int v = 0; v < 6; v++) begin
      logic [5:0] lc;
      logic       useFall;
      lc      = VEC[v][7:2];
      useFall = VEC[v][1];
      doReset();
      srcSelA = VEC[v][0];
      lenSel  = lc;
      for (int i = 0; i < int'(lc) + 3; i++) begin
        logic b;
        b = ((i * 5 + v) % 3) == 0;
        if (useFall) shiftFall(b); else shiftRise(b);
        chk(useFall ? "R1 R2 R3 R6 vector tap" : "R1 R2 R3 R5 vector tap",
            qOut, mdl[lc]);
        chk("R8 vector complement", qOutN, ~mdl[lc]);
      end
    end

    // R9: re-tap stored data by changing the length word
    for (int k = 0; k < 4; k++) begin
      logic [5:0] code;
      code = (k == 0) ? 6'd0 : (k == 1) ? 6'd7 : (k == 2) ? 6'd31 : 6'd50;
      @(negedge clk);
      lenSel = code;
      #0.5;
      chk("R9 retap", qOut, mdl[code]);
    end
    @(negedge clk);
    lenSel = 6'd63;
    settle();
    chk("R9 data kept", qOut, mdl[63]);

    // R5 / R6 negative cases
    doReset();
    srcSelA = 1'b1;
    lenSel  = 6'd0;
    shiftRise(1'b1);
    chk("R5 setup", qOut, 1'b1);
    dinA   = 1'b0;
    shClkB = 1'b1;
    settle();
    shClkA = 1'b1;
    settle();
    chk("R5 rise with B high ignored", qOut, 1'b1);
    shClkA = 1'b0;
    settle();
    shClkB = 1'b0;
    settle();
    chk("R6 fall with A low ignored", qOut, 1'b1);

    // R10: both trigger conditions together give one shift
    doReset();
    lenSel = 6'd1;
    shiftRise(1'b1);
    chk("R10 setup", qOut, 1'b0);
    dinA   = 1'b0;
    shClkB = 1'b1;
    settle();
    shClkA = 1'b1;
    shClkB = 1'b0;
    settle();
    mdl = {mdl[62:0], 1'b0};
    chk("R10 single step", qOut, mdl[1]);
    shClkA = 1'b0;
    settle();

    // R10: latency of three system edges
    doReset();
    lenSel = 6'd0;
    dinA   = 1'b1;
    shClkA = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 not yet after two edges", qOut, 1'b0);
    @(negedge clk);
    chk("R10 shifted at third edge", qOut, 1'b1);
    shClkA = 1'b0;
    settle();

    // R7: asynchronous clear
    #1;
    clear = 1'b1;
    #0.5;
    chk("R7 async clear qOut", qOut, 1'b0);
    chk("R7 async clear qOutN", qOutN, 1'b1);
    @(negedge clk);
    clear = 1'b0;
    settle();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule